// File: doc/BRIEF.md
# Pointer-Masking Mode Configuration Register Legalizer

This block keeps the pointer-masking mode fields of five control registers: the machine security configuration, the machine, supervisor and hypervisor environment configurations, and the hypervisor status word. A control-register request arrives as an address, a write enable and a 64-bit data word. Read data comes back in the same cycle as the pre-write value. Writes are legalized on the way in. The reserved mode code is forced to zero. The cache-block-invalidate field of the environment registers drops its reserved code. Bits outside the write mask of a register keep their value.

Each mode field is writable only while its extension enable is high, and it reads as zero while that enable is low. The machine security register may be accessed only when at least one of four feature enables is set. An access outside that rule, or to an address the block does not own, sets the illegal flag. Such an access leaves all state unchanged and returns zero. Any write that changes a mode field in an environment register or in the hypervisor status word makes the block raise a one-cycle translation-cache flush request in the cycle after the write.

Top module: `pmm_cfg_legalizer`

## Requirements
- R1: After reset, every stored field reads as zero, except the read-only guest-width field at hypervisor-status bits 33:32. That field holds the width code for the configured register width (1 for 32, 2 for 64, 3 otherwise).
- R2: A mode field is 2 bits wide. It sits at bits 33:32 in the security and environment registers and at bits 49:48 in hypervisor status. A write of code 1 stores 0, and writes of 0, 2 and 3 are stored unchanged.
- R3: The security-register mode field is written only while `ext_pm_mach` is high. While that enable is low, a write leaves it unchanged and reads return 0 in those bits.
- R4: Any access to the security register (address 0x747) while `ext_pmp_enh`, `ext_pm_mach`, `ext_lpad` and `ext_entropy` are all low sets `csr_illegal`, returns zero read data and changes no state.
- R5: The machine environment register (0x30A) mode field is gated by `ext_pm_lower`. The supervisor (0x10A) and hypervisor (0x60A) environment mode fields are gated by `ext_pm_sup`. A gated-off field ignores writes and reads as 0.
- R6: The cache-block-invalidate field at bits 5:4 of each environment register stores 0 when written with code 2 and stores any other code unchanged.
- R7: A legal write to an environment register whose stored mode field changes raises `tlb_flush` for exactly the following cycle. A write to the security register, or a write that leaves the mode unchanged, raises no flush.
- R8: In hypervisor status (0x600), only bits 22, 21, 9, 8, 7 and 6 are always writable. Bit 20 is writable only with `mmu_present`, and bits 49:48 only with `ext_pm_sup`. Every other bit, the guest-width field included, keeps its value.
- R9: A legal write to hypervisor status that changes bits 49:48 raises `tlb_flush` for the following cycle.
- R10: A request to any other address sets `csr_illegal`, returns zero and changes no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ext_pmp_enh | input | 1 | Memory-protection enhancement feature present |
| ext_pm_mach | input | 1 | Machine-level pointer masking present |
| ext_pm_lower | input | 1 | Pointer masking for the next lower level, set from machine level |
| ext_pm_sup | input | 1 | Supervisor-controlled pointer masking present |
| ext_lpad | input | 1 | Landing-pad feature present |
| ext_entropy | input | 1 | Entropy-source feature present |
| mmu_present | input | 1 | Address translation hardware present |
| csr_req | input | 1 | Request valid |
| csr_we | input | 1 | Request is a write |
| csr_addr | input | 12 | Register address |
| csr_wdata | input | 64 | Write data |
| csr_rdata | output | 64 | Read data (current value, combinational) |
| csr_illegal | output | 1 | Access not permitted or unmapped |
| tlb_flush | output | 1 | One-cycle flush request after a mode change |

## Verification
A single write can fold a reserved mode code to zero and, because of that folding, decide whether a flush is raised. Writing code 1 over a stored nonzero mode must flush. Writing code 1 over a stored zero must not. The bench drives both cases and random mixes of mode codes against a stored model. In the same cycle it compares the read data, the illegal flag and the flush pulse with the model's prediction. Enable toggling between writes also makes gating and change detection meet: a gated-off field must neither change nor flush.

// File: rtl/pmm_csr_pkg.sv
package pmm_csr_pkg;

    localparam int unsigned REG_W    = 64;
    localparam int unsigned NUM_ENV  = 3;
    localparam int unsigned PMM_W    = 2;
    localparam int unsigned PMM_LO   = 32;
    localparam int unsigned HUPMM_LO = 48;
    localparam int unsigned CBIE_LO  = 4;
    localparam int unsigned CBIE_W   = 2;
    localparam int unsigned VSXL_LO  = 32;

    localparam int unsigned HS_GVA   = 6;
    localparam int unsigned HS_SPV   = 7;
    localparam int unsigned HS_SPVP  = 8;
    localparam int unsigned HS_HU    = 9;
    localparam int unsigned HS_VTVM  = 20;
    localparam int unsigned HS_VTW   = 21;
    localparam int unsigned HS_VTSR  = 22;

    localparam logic [PMM_W-1:0]  PMM_RSVD  = 2'd1;
    localparam logic [CBIE_W-1:0] CBIE_RSVD = 2'd2;

    typedef logic [REG_W-1:0] word_t;

    typedef enum logic [2:0] {
        SEL_NONE,
        SEL_SEC,
        SEL_MENV,
        SEL_SENV,
        SEL_HENV,
        SEL_HST
    } csr_sel_e;

    typedef struct packed {
        word_t                sec;
        word_t [NUM_ENV-1:0]  env;
        word_t                hst;
        logic                 flush;
    } pmm_state_t;

    function automatic word_t field_mask(input int unsigned lo, input int unsigned w);
        word_t m;
        m = '0;
        for (int unsigned i = 0; i < REG_W; i++) begin
            if (i >= lo && i < lo + w) m[i] = 1'b1;
        end
        return m;
    endfunction

    function automatic logic [1:0] width_code(input int unsigned xlen);
        if (xlen == 32) return 2'd1;
        if (xlen == 64) return 2'd2;
        return 2'd3;
    endfunction

endpackage

// File: rtl/pmm_warl_field.sv
module pmm_warl_field #(
    parameter int unsigned     W        = 2,
    parameter logic [W-1:0]    RESERVED = '0
) (
    input  logic [W-1:0] raw_in,
    output logic [W-1:0] legal_out
);
    always_comb begin
        legal_out = (raw_in == RESERVED) ? '0 : raw_in;
    end
endmodule

// File: rtl/pmm_csr_decode.sv
module pmm_csr_decode
    import pmm_csr_pkg::*;
#(
    parameter logic [11:0] A_SEC  = 12'h747,
    parameter logic [11:0] A_MENV = 12'h30A,
    parameter logic [11:0] A_SENV = 12'h10A,
    parameter logic [11:0] A_HENV = 12'h60A,
    parameter logic [11:0] A_HST  = 12'h600
) (
    input  logic        req,
    input  logic [11:0] addr,
    input  logic        sec_open,
    output csr_sel_e    sel,
    output logic        illegal
);
    always_comb begin
        case (addr)
            A_SEC:   sel = SEL_SEC;
            A_MENV:  sel = SEL_MENV;
            A_SENV:  sel = SEL_SENV;
            A_HENV:  sel = SEL_HENV;
            A_HST:   sel = SEL_HST;
            default: sel = SEL_NONE;
        endcase
        illegal = req && ((sel == SEL_NONE) || (sel == SEL_SEC && !sec_open));
    end
endmodule

// File: rtl/pmm_cfg_legalizer.sv
module pmm_cfg_legalizer
    import pmm_csr_pkg::*;
#(
    parameter int unsigned XLEN   = 64,
    parameter logic [11:0] A_SEC  = 12'h747,
    parameter logic [11:0] A_MENV = 12'h30A,
    parameter logic [11:0] A_SENV = 12'h10A,
    parameter logic [11:0] A_HENV = 12'h60A,
    parameter logic [11:0] A_HST  = 12'h600
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        ext_pmp_enh,
    input  logic        ext_pm_mach,
    input  logic        ext_pm_lower,
    input  logic        ext_pm_sup,
    input  logic        ext_lpad,
    input  logic        ext_entropy,
    input  logic        mmu_present,
    input  logic        csr_req,
    input  logic        csr_we,
    input  logic [11:0] csr_addr,
    input  logic [63:0] csr_wdata,
    output logic [63:0] csr_rdata,
    output logic        csr_illegal,
    output logic        tlb_flush
);
    localparam logic [1:0] VSXL_CODE = width_code(XLEN);
    localparam word_t PMM_M   = field_mask(PMM_LO, PMM_W);
    localparam word_t HUPMM_M = field_mask(HUPMM_LO, PMM_W);
    localparam word_t CBIE_M  = field_mask(CBIE_LO, CBIE_W);
    localparam word_t HST_BASE_M = field_mask(HS_VTSR, 1) | field_mask(HS_VTW, 1)
                                 | field_mask(HS_HU, 1)   | field_mask(HS_SPVP, 1)
                                 | field_mask(HS_SPV, 1)  | field_mask(HS_GVA, 1);
    localparam word_t VTVM_M  = field_mask(HS_VTVM, 1);
    localparam word_t HST_RST = word_t'(VSXL_CODE) << VSXL_LO;

    pmm_state_t st_d, st_q;

    csr_sel_e    sel;
    logic        wr;
    logic        sec_open;
    logic [1:0]  pmm_fixed, hupmm_fixed, cbie_fixed;
    word_t       wd_sec, wd_env, wd_hst;
    word_t       sec_wmask, sec_rmask, hst_wmask, hst_rmask;
    word_t       sec_nxt, hst_nxt;
    word_t       rd_sel;
    logic [NUM_ENV-1:0] env_gate;
    logic [NUM_ENV-1:0] env_chg;
    word_t [NUM_ENV-1:0] env_wmask, env_rmask, env_nxt;

    assign sec_open = ext_pmp_enh | ext_pm_mach | ext_lpad | ext_entropy;
    assign env_gate = {ext_pm_sup, ext_pm_sup, ext_pm_lower};

    pmm_csr_decode #(
        .A_SEC (A_SEC), .A_MENV(A_MENV), .A_SENV(A_SENV),
        .A_HENV(A_HENV), .A_HST (A_HST)
    ) u_decode (
        .req     (csr_req),
        .addr    (csr_addr),
        .sec_open(sec_open),
        .sel     (sel),
        .illegal (csr_illegal)
    );

    pmm_warl_field #(.W(PMM_W), .RESERVED(PMM_RSVD)) u_fix_pmm (
        .raw_in   (csr_wdata[PMM_LO +: PMM_W]),
        .legal_out(pmm_fixed)
    );

    pmm_warl_field #(.W(PMM_W), .RESERVED(PMM_RSVD)) u_fix_hupmm (
        .raw_in   (csr_wdata[HUPMM_LO +: PMM_W]),
        .legal_out(hupmm_fixed)
    );

    pmm_warl_field #(.W(CBIE_W), .RESERVED(CBIE_RSVD)) u_fix_cbie (
        .raw_in   (csr_wdata[CBIE_LO +: CBIE_W]),
        .legal_out(cbie_fixed)
    );

    // legalized write words and per-register masks
    always_comb begin
        wd_sec = csr_wdata;
        wd_sec[PMM_LO +: PMM_W] = pmm_fixed;
        wd_env = wd_sec;
        wd_env[CBIE_LO +: CBIE_W] = cbie_fixed;
        wd_hst = csr_wdata;
        wd_hst[HUPMM_LO +: PMM_W] = hupmm_fixed;

        sec_wmask = ext_pm_mach ? PMM_M : '0;
        sec_rmask = ext_pm_mach ? '1 : ~PMM_M;
        hst_wmask = HST_BASE_M | (mmu_present ? VTVM_M : '0) | (ext_pm_sup ? HUPMM_M : '0);
        hst_rmask = ext_pm_sup ? '1 : ~HUPMM_M;

        sec_nxt = (st_q.sec & ~sec_wmask) | (wd_sec & sec_wmask);
        hst_nxt = (st_q.hst & ~hst_wmask) | (wd_hst & hst_wmask);
    end

    for (genvar gi = 0; gi < NUM_ENV; gi++) begin : g_env
        always_comb begin
            env_wmask[gi] = CBIE_M | (env_gate[gi] ? PMM_M : '0);
            env_rmask[gi] = env_gate[gi] ? '1 : ~PMM_M;
            env_nxt[gi]   = (st_q.env[gi] & ~env_wmask[gi]) | (wd_env & env_wmask[gi]);
            env_chg[gi]   = env_nxt[gi][PMM_LO +: PMM_W] != st_q.env[gi][PMM_LO +: PMM_W];
        end

        // R2
        pmm_env_no_rsvd_chk: assert property (@(posedge clk) disable iff (!rst_n)
            st_q.env[gi][PMM_LO +: PMM_W] != PMM_RSVD);

        // R6
        cbie_no_rsvd_chk: assert property (@(posedge clk) disable iff (!rst_n)
            st_q.env[gi][CBIE_LO +: CBIE_W] != CBIE_RSVD);
    end

    // next-state and read path
    always_comb begin
        st_d       = st_q;
        st_d.flush = 1'b0;
        wr         = csr_req && csr_we && !csr_illegal;
        rd_sel     = '0;
        case (sel)
            SEL_SEC: begin
                rd_sel = st_q.sec & sec_rmask;
                if (wr) st_d.sec = sec_nxt;
            end
            SEL_MENV: begin
                rd_sel = st_q.env[0] & env_rmask[0];
                if (wr) begin
                    st_d.env[0] = env_nxt[0];
                    st_d.flush  = env_chg[0];
                end
            end
            SEL_SENV: begin
                rd_sel = st_q.env[1] & env_rmask[1];
                if (wr) begin
                    st_d.env[1] = env_nxt[1];
                    st_d.flush  = env_chg[1];
                end
            end
            SEL_HENV: begin
                rd_sel = st_q.env[2] & env_rmask[2];
                if (wr) begin
                    st_d.env[2] = env_nxt[2];
                    st_d.flush  = env_chg[2];
                end
            end
            SEL_HST: begin
                rd_sel = st_q.hst & hst_rmask;
                if (wr) begin
                    st_d.hst   = hst_nxt;
                    st_d.flush = hst_nxt[HUPMM_LO +: PMM_W] != st_q.hst[HUPMM_LO +: PMM_W];
                end
            end
            default: rd_sel = '0;
        endcase
        csr_rdata = (csr_req && !csr_illegal) ? rd_sel : '0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.sec   <= '0;
            st_q.env   <= '0;
            st_q.hst   <= HST_RST;
            st_q.flush <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign tlb_flush = st_q.flush;

    // R7
    flush_needs_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tlb_flush |-> $past(csr_req && csr_we && !csr_illegal));

    // R4
    illegal_keeps_state_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (csr_req && csr_illegal) |=> ($stable(st_q.sec) && $stable(st_q.env) && $stable(st_q.hst) && !tlb_flush));

    // R3
    sec_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (csr_req && csr_we && sel == SEL_SEC && !ext_pm_mach) |=> $stable(st_q.sec));

    // R8
    vsxl_fixed_chk: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.hst[VSXL_LO +: 2] == VSXL_CODE);

    // R2
    pmm_sec_no_rsvd_chk: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.sec[PMM_LO +: PMM_W] != PMM_RSVD && st_q.hst[HUPMM_LO +: PMM_W] != PMM_RSVD);

endmodule

// File: tb/tb_pmm_cfg_legalizer.sv
module tb_pmm_cfg_legalizer;
    localparam int CLK_PERIOD = 10;
    localparam logic [11:0] A_SEC = 12'h747, A_MENV = 12'h30A, A_SENV = 12'h10A,
                            A_HENV = 12'h60A, A_HST = 12'h600;

    logic clk = 0, rst_n = 0;
    logic ext_pmp_enh = 0, ext_pm_mach = 0, ext_pm_lower = 0, ext_pm_sup = 0;
    logic ext_lpad = 0, ext_entropy = 0, mmu_present = 0;
    logic csr_req = 0, csr_we = 0;
    logic [11:0] csr_addr = '0;
    logic [63:0] csr_wdata = '0;
    logic [63:0] csr_rdata;
    logic csr_illegal, tlb_flush;

    int n_chk = 0, n_fail = 0;
    logic [63:0] m_sec, m_hst;
    logic [63:0] m_env [3];

    always #(CLK_PERIOD/2) clk = ~clk;

    pmm_cfg_legalizer dut (.*);

    function automatic logic [63:0] fm(input int lo, input int w);
        logic [63:0] m = '0;
        for (int i = lo; i < lo + w; i++) m[i] = 1'b1;
        return m;
    endfunction

    function automatic logic [1:0] fold(input logic [1:0] v, input logic [1:0] r);
        return (v == r) ? 2'd0 : v;
    endfunction

    function automatic int env_idx(input logic [11:0] a);
        if (a == A_MENV) return 0;
        if (a == A_SENV) return 1;
        if (a == A_HENV) return 2;
        return -1;
    endfunction

    function automatic logic env_en(input int i);
        return (i == 0) ? ext_pm_lower : ext_pm_sup;
    endfunction

    task automatic chk(input logic ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic op(input logic [11:0] a, input logic we, input logic [63:0] wd);
        logic exp_ill, exp_fl;
        logic [63:0] exp_rd, wmask, nv, lw;
        int ei;
        string tag;
        @(negedge clk);
        csr_req = 1; csr_we = we; csr_addr = a; csr_wdata = wd;
        #1;
        ei = env_idx(a);
        exp_ill = 0; exp_rd = '0; exp_fl = 0; tag = "R10";
        lw = wd;
        if (a == A_SEC) begin
            tag = "R3";
            exp_ill = !(ext_pmp_enh | ext_pm_mach | ext_lpad | ext_entropy);
            if (exp_ill) tag = "R4";
            exp_rd = ext_pm_mach ? m_sec : (m_sec & ~fm(32, 2));
            lw[33:32] = fold(wd[33:32], 2'd1);
            wmask = ext_pm_mach ? fm(32, 2) : '0;
            nv = (m_sec & ~wmask) | (lw & wmask);
            if (we && !exp_ill) m_sec = nv;
        end else if (ei >= 0) begin
            tag = "R5";
            exp_rd = env_en(ei) ? m_env[ei] : (m_env[ei] & ~fm(32, 2));
            lw[33:32] = fold(wd[33:32], 2'd1);
            lw[5:4] = fold(wd[5:4], 2'd2);
            wmask = fm(4, 2) | (env_en(ei) ? fm(32, 2) : '0);
            nv = (m_env[ei] & ~wmask) | (lw & wmask);
            if (we) begin
                exp_fl = nv[33:32] != m_env[ei][33:32];
                m_env[ei] = nv;
            end
        end else if (a == A_HST) begin
            tag = "R8";
            exp_rd = ext_pm_sup ? m_hst : (m_hst & ~fm(48, 2));
            lw[49:48] = fold(wd[49:48], 2'd1);
            wmask = fm(22,1) | fm(21,1) | fm(9,1) | fm(8,1) | fm(7,1) | fm(6,1)
                  | (mmu_present ? fm(20,1) : '0) | (ext_pm_sup ? fm(48,2) : '0);
            nv = (m_hst & ~wmask) | (lw & wmask);
            if (we) begin
                exp_fl = nv[49:48] != m_hst[49:48];
                m_hst = nv;
            end
        end else begin
            exp_ill = 1;
        end
        chk(csr_illegal == exp_ill, exp_ill ? tag : {tag, " legal"}, 64'(csr_illegal), 64'(exp_ill));
        chk(csr_rdata == exp_rd, {tag, " rdata"}, csr_rdata, exp_rd);
        @(posedge clk); #1;
        chk(tlb_flush == exp_fl, (a == A_HST) ? "R9 flush" : "R7 flush", 64'(tlb_flush), 64'(exp_fl));
        csr_req = 0; csr_we = 0;
    endtask

    task automatic all_on();
        ext_pmp_enh = 1; ext_pm_mach = 1; ext_pm_lower = 1; ext_pm_sup = 1;
        ext_lpad = 1; ext_entropy = 1; mmu_present = 1;
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        n_fail++; n_chk++;
        $display("FAIL watchdog expired");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        logic [11:0] addrs [6];
        void'($urandom(32'h5eed_1234));
        addrs = '{A_SEC, A_MENV, A_SENV, A_HENV, A_HST, 12'h123};
        m_sec = '0; m_env[0] = '0; m_env[1] = '0; m_env[2] = '0;
        m_hst = 64'(2) << 32;
        repeat (3) @(posedge clk);
        rst_n = 1;
        // R1 reset values
        ext_pmp_enh = 1;
        @(negedge clk); csr_req = 1; csr_we = 0; csr_addr = A_HST; #1;
        chk(csr_rdata == (64'(2) << 32), "R1 hst reset", csr_rdata, 64'(2) << 32);
        csr_addr = A_MENV; #1;
        chk(csr_rdata == 0, "R1 menv reset", csr_rdata, 0);
        csr_addr = A_SEC; #1;
        chk(csr_rdata == 0 && tlb_flush == 0, "R1 sec reset", csr_rdata, 0);
        csr_req = 0;
        // R2 reserved fold over nonzero then zero
        all_on();
        op(A_MENV, 1, 64'(3) << 32);
        op(A_MENV, 1, 64'(1) << 32);   // R2: 3 -> 0, flush R7
        op(A_MENV, 1, 64'(1) << 32);   // R7: unchanged, no flush
        op(A_SENV, 1, 64'(2) << 32);
        op(A_SENV, 0, 0);
        // R6 cbie reserved
        op(A_HENV, 1, 64'h20);
        op(A_HENV, 1, 64'h30);
        op(A_HENV, 0, 0);
        // R3 security gating, no flush on security write
        op(A_SEC, 1, 64'(3) << 32);
        ext_pm_mach = 0;
        op(A_SEC, 1, 64'(2) << 32);
        op(A_SEC, 0, 0);
        // R4 security illegal
        ext_pmp_enh = 0; ext_lpad = 0; ext_entropy = 0;
        op(A_SEC, 1, '1);
        ext_pm_mach = 1;
        op(A_SEC, 0, 0);
        // R5 gated-off env fields
        ext_pm_lower = 0;
        op(A_MENV, 1, 64'(2) << 32);
        ext_pm_lower = 1;
        op(A_MENV, 0, 0);
        // R8 hstatus mask, R9 flush
        mmu_present = 0;
        op(A_HST, 1, '1);
        op(A_HST, 1, 64'(1) << 48);
        mmu_present = 1;
        op(A_HST, 1, 64'h0070_0000);
        op(A_HST, 0, 0);
        // R10 unmapped
        op(12'hABC, 1, '1);
        // random mix
        for (int k = 0; k < 600; k++) begin
            logic [63:0] wd;
            if ($urandom_range(0, 3) == 0) begin
                ext_pmp_enh = 1'($urandom); ext_pm_mach = 1'($urandom);
                ext_pm_lower = 1'($urandom); ext_pm_sup = 1'($urandom);
                ext_lpad = 1'($urandom); ext_entropy = 1'($urandom);
                mmu_present = 1'($urandom);
            end
            wd = {$urandom, $urandom};
            op(addrs[$urandom_range(0, 5)], 1'($urandom_range(0, 3) != 0), wd);
        end
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule